// File: doc/BRIEF.md
# Command Register Sequencer

A write-only, one-byte command register for a communications controller. Each host write that hits the register's address is decoded into per-function strobes for the signalling-channel transmit and receive paths, and into latched mode levels for a software reset and two loopback controls. A bit written as 0 never does anything. Only a 1 triggers its action. Path resets, path enables and the error clear are strobes that clear themselves. The software reset and the loopback bits are levels.

When a path reset arrives in the same write as other command bits, the reset takes effect first. The other bits are parked and applied one cycle later. The software reset must be written on its own. Any other combination with it is refused and flagged. Small stub models of the two FIFO fill levels, the transmit idle-fill state and a sticky isochronous-OUT error flag make the effect of every command visible at the ports.

Bit map of the command byte (bit 7 first): transmit path reset, receive path reset, transmit enable, receive enable, software reset, clear isochronous error, digital loopback, auxiliary loopback.

Top module: `cmdreg_seq`

## Requirements
- R1: After the asynchronous reset (rst_n low), every output is 0 except tx_idle_fill, which is 1.
- R2: A write is taken only when wr_en is 1 and wr_addr equals CMD_ADDR. A write to any other address, or a write of 0x00, changes no output.
- R3: Bit 5 (transmit enable) or bit 4 (receive enable) sets tx_active or rx_active at the accepting clock edge. It also raises tx_en_pulse or rx_en_pulse for exactly that one following cycle.
- R4: Bit 7 (transmit reset) clears tx_level and tx_active, so tx_idle_fill becomes 1, and raises tx_rst_pulse for one cycle. Bit 6 does the same for rx_level and rx_active with rx_rst_pulse. The other path is not touched.
- R5: If bit 7 or bit 6 is written together with any of bits 5, 4, 2, 1, 0, then the reset acts at the accepting edge and the remaining bits act at the next edge. Any write that arrives in that second cycle is ignored.
- R6: Writing exactly 0x08 sets sw_rst, which stays 1. While it is 1, all other state is held at its reset value and every write with bit 3 set is ignored. A write with bit 3 clear ends the software reset, and all its other bits are ignored.
- R7: A write with bit 3 set and any other bit set is ignored and sets cmd_err. cmd_err stays 1 until the next accepted write without bit 3, or a software reset.
- R8: Bit 1 sets lb_digital and bit 0 sets lb_aux. Each stays 1 until a software reset.
- R9: iso_err_set sets the sticky iso_err. Bit 2 clears it and raises iso_clr_pulse for one cycle. A clear wins over a set at the same edge.
- R10: tx_push (rx_push) increments tx_level (rx_level) only when the path was already active before that edge. The level saturates at FIFO_DEPTH, and a path reset at the same edge wins over a push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write address |
| wr_data | input | 8 | Host write data (command byte) |
| tx_push | input | 1 | Stub: one entry into the transmit FIFO |
| rx_push | input | 1 | Stub: one entry into the receive FIFO |
| iso_err_set | input | 1 | Stub: isochronous-OUT error event |
| tx_rst_pulse | output | 1 | One-cycle transmit path reset strobe |
| rx_rst_pulse | output | 1 | One-cycle receive path reset strobe |
| tx_en_pulse | output | 1 | One-cycle transmit enable strobe |
| rx_en_pulse | output | 1 | One-cycle receive enable strobe |
| iso_clr_pulse | output | 1 | One-cycle error-clear strobe |
| sw_rst | output | 1 | Software reset level |
| lb_digital | output | 1 | Digital loopback level |
| lb_aux | output | 1 | Auxiliary loopback level |
| tx_active | output | 1 | Transmit FIFO enabled |
| rx_active | output | 1 | Receive FIFO enabled |
| tx_idle_fill | output | 1 | Transmitter sending all-ones fill |
| tx_level | output | LW | Stub transmit FIFO fill level |
| rx_level | output | LW | Stub receive FIFO fill level |
| iso_err | output | 1 | Sticky isochronous-OUT error flag |
| cmd_err | output | 1 | Sticky illegal-write flag |

## Verification
The bench builds the block with CMD_ADDR = 0x21 and FIFO_DEPTH = 3. The non-default address lets a write to the usual address 0x01 serve as a foreign-address case. The shallow depth lets a handful of pushes hit saturation, and a path reset then clears a full FIFO. A behavioural model tracks every output on every clock. It follows the two-step reset ordering, the ignored write in the deferred cycle, the refused software-reset combinations and the exit from software reset.

// File: rtl/cmdreg_seq.sv
module cmdreg_seq #(
  parameter int AW = 8,
  parameter logic [AW-1:0] CMD_ADDR = 1,
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          tx_push,
  input  logic          rx_push,
  input  logic          iso_err_set,
  output logic          tx_rst_pulse,
  output logic          rx_rst_pulse,
  output logic          tx_en_pulse,
  output logic          rx_en_pulse,
  output logic          iso_clr_pulse,
  output logic          sw_rst,
  output logic          lb_digital,
  output logic          lb_aux,
  output logic          tx_active,
  output logic          rx_active,
  output logic          tx_idle_fill,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic          iso_err,
  output logic          cmd_err
);
  localparam logic [7:0] SW_ONLY = 8'h08;
  localparam logic [7:0] DEFER_MASK = 8'h37;
  localparam logic [LW-1:0] LVL_MAX = LW'(FIFO_DEPTH);

  logic       seq;
  logic [7:0] pend;

  wire hit      = wr_en && (wr_addr == CMD_ADDR);
  wire take     = hit && !sw_rst && !seq;
  wire sw_enter = take && (wr_data == SW_ONLY);
  wire illegal  = take && wr_data[3] && (wr_data != SW_ONLY);
  wire legal    = take && !wr_data[3];
  wire clr_tx   = legal && wr_data[7];
  wire clr_rx   = legal && wr_data[6];
  wire prst     = clr_tx || clr_rx;
  wire sw_exit  = sw_rst && hit && !wr_data[3];
  wire hold     = sw_rst || sw_enter;
  wire [7:0] act = seq ? pend : ((legal && !prst) ? wr_data : 8'h00);

  assign tx_idle_fill = !tx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_rst <= 1'b0;
    end else if (sw_enter) begin
      sw_rst <= 1'b1;
    end else if (sw_exit) begin
      sw_rst <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= 1'b0;
      pend <= '0;
      tx_rst_pulse <= 1'b0;
      rx_rst_pulse <= 1'b0;
      tx_en_pulse <= 1'b0;
      rx_en_pulse <= 1'b0;
      iso_clr_pulse <= 1'b0;
    end else begin
      seq <= prst;
      pend <= prst ? (wr_data & DEFER_MASK) : 8'h00;
      tx_rst_pulse <= clr_tx;
      rx_rst_pulse <= clr_rx;
      tx_en_pulse <= act[5];
      rx_en_pulse <= act[4];
      iso_clr_pulse <= act[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_active <= 1'b0;
      rx_active <= 1'b0;
      tx_level <= '0;
      rx_level <= '0;
    end else if (hold) begin
      tx_active <= 1'b0;
      rx_active <= 1'b0;
      tx_level <= '0;
      rx_level <= '0;
    end else begin
      if (clr_tx) tx_active <= 1'b0;
      else if (act[5]) tx_active <= 1'b1;
      if (clr_rx) rx_active <= 1'b0;
      else if (act[4]) rx_active <= 1'b1;
      if (clr_tx) tx_level <= '0;
      else if (tx_push && tx_active && tx_level < LVL_MAX) tx_level <= tx_level + 1'b1;
      if (clr_rx) rx_level <= '0;
      else if (rx_push && rx_active && rx_level < LVL_MAX) rx_level <= rx_level + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iso_err <= 1'b0;
      lb_digital <= 1'b0;
      lb_aux <= 1'b0;
      cmd_err <= 1'b0;
    end else if (hold) begin
      iso_err <= 1'b0;
      lb_digital <= 1'b0;
      lb_aux <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      if (act[2]) iso_err <= 1'b0;
      else if (iso_err_set) iso_err <= 1'b1;
      if (act[1]) lb_digital <= 1'b1;
      if (act[0]) lb_aux <= 1'b1;
      if (illegal) cmd_err <= 1'b1;
      else if (legal) cmd_err <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdreg_seq_chk.sv
module cmdreg_seq_chk #(
  parameter int AW = 8,
  parameter logic [AW-1:0] CMD_ADDR = 1,
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          tx_rst_pulse,
  input logic          tx_en_pulse,
  input logic          rx_rst_pulse,
  input logic          sw_rst,
  input logic          lb_digital,
  input logic          lb_aux,
  input logic          tx_active,
  input logic          rx_active,
  input logic          tx_idle_fill,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          iso_err,
  input logic          cmd_err
);
  assert_en_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_pulse |-> tx_active);

  assert_txrst_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_pulse |-> (!tx_active && tx_level == '0 && tx_idle_fill));

  assert_rxrst_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_pulse |-> (!rx_active && rx_level == '0));

  assert_reset_before_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_pulse |-> !tx_en_pulse);

  assert_sw_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |-> (!tx_active && !rx_active && !lb_digital && !lb_aux && !iso_err && !cmd_err));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> $past(wr_en && wr_addr == CMD_ADDR && wr_data[3]));

  assert_loop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lb_digital) || $fell(lb_aux)) |-> sw_rst);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(FIFO_DEPTH)) && (rx_level <= LW'(FIFO_DEPTH)));
endmodule

bind cmdreg_seq cmdreg_seq_chk #(.AW(AW), .CMD_ADDR(CMD_ADDR), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tx_rst_pulse(tx_rst_pulse), .tx_en_pulse(tx_en_pulse), .rx_rst_pulse(rx_rst_pulse),
  .sw_rst(sw_rst), .lb_digital(lb_digital), .lb_aux(lb_aux),
  .tx_active(tx_active), .rx_active(rx_active), .tx_idle_fill(tx_idle_fill),
  .tx_level(tx_level), .rx_level(rx_level), .iso_err(iso_err), .cmd_err(cmd_err)
);

// File: tb/cmdreg_seq_test.sv
module cmdreg_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam logic [AW-1:0] A = 8'h21;
  localparam int D = 3;
  localparam int LW = $clog2(D + 1);

  logic clk = 0, rst_n = 0, wr_en = 0, tx_push = 0, rx_push = 0, iso_err_set = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic tx_rst_pulse, rx_rst_pulse, tx_en_pulse, rx_en_pulse, iso_clr_pulse;
  logic sw_rst, lb_digital, lb_aux, tx_active, rx_active, tx_idle_fill, iso_err, cmd_err;
  logic [LW-1:0] tx_level, rx_level;

  cmdreg_seq #(.AW(AW), .CMD_ADDR(A), .FIFO_DEPTH(D)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nbad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  // behavioural reference
  int m_txa, m_rxa, m_txl, m_rxl, m_sw, m_lbd, m_lba, m_iso, m_cerr, m_seq;
  int p_txr, p_rxr, p_txe, p_rxe, p_iso;
  logic [7:0] m_pend;

  always @(posedge clk) begin
    logic [7:0] a, d;
    bit hitw, ctx, crx, enter;
    cyc++;
    if (!rst_n) begin
      m_txa = 0; m_rxa = 0; m_txl = 0; m_rxl = 0; m_sw = 0; m_lbd = 0; m_lba = 0;
      m_iso = 0; m_cerr = 0; m_seq = 0; m_pend = 0;
      p_txr = 0; p_rxr = 0; p_txe = 0; p_rxe = 0; p_iso = 0;
    end else begin
      hitw = wr_en && wr_addr == A; d = wr_data;
      p_txr = 0; p_rxr = 0; p_txe = 0; p_rxe = 0; p_iso = 0;
      if (m_sw != 0) begin
        if (hitw && !d[3]) m_sw = 0;
      end else begin
        a = 0; ctx = 0; crx = 0; enter = 0;
        if (m_seq != 0) begin a = m_pend; m_seq = 0; end
        else if (hitw) begin
          if (d[3]) begin
            if (d == 8'h08) enter = 1; else m_cerr = 1;
          end else begin
            m_cerr = 0;
            if (d[7] || d[6]) begin ctx = d[7]; crx = d[6]; m_seq = 1; m_pend = d & 8'h37; end
            else a = d;
          end
        end
        if (ctx) m_txl = 0; else if (tx_push && m_txa != 0 && m_txl < D) m_txl++;
        if (crx) m_rxl = 0; else if (rx_push && m_rxa != 0 && m_rxl < D) m_rxl++;
        if (ctx) m_txa = 0; else if (a[5]) m_txa = 1;
        if (crx) m_rxa = 0; else if (a[4]) m_rxa = 1;
        if (a[2]) m_iso = 0; else if (iso_err_set) m_iso = 1;
        if (a[1]) m_lbd = 1;
        if (a[0]) m_lba = 1;
        p_txr = ctx; p_rxr = crx; p_txe = a[5]; p_rxe = a[4]; p_iso = a[2];
        if (enter) begin
          m_sw = 1; m_txa = 0; m_rxa = 0; m_txl = 0; m_rxl = 0; m_lbd = 0; m_lba = 0;
          m_iso = 0; m_cerr = 0; m_seq = 0;
          p_txr = 0; p_rxr = 0; p_txe = 0; p_rxe = 0; p_iso = 0;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R4", "tx_rst_pulse", tx_rst_pulse, p_txr);
    chk("R4", "rx_rst_pulse", rx_rst_pulse, p_rxr);
    chk("R4", "tx_idle_fill", tx_idle_fill, m_txa == 0);
    chk("R3", "tx_en_pulse", tx_en_pulse, p_txe);
    chk("R3", "rx_en_pulse", rx_en_pulse, p_rxe);
    chk("R3", "tx_active", tx_active, m_txa);
    chk("R3", "rx_active", rx_active, m_rxa);
    chk("R9", "iso_clr_pulse", iso_clr_pulse, p_iso);
    chk("R9", "iso_err", iso_err, m_iso);
    chk("R6", "sw_rst", sw_rst, m_sw);
    chk("R8", "lb_digital", lb_digital, m_lbd);
    chk("R8", "lb_aux", lb_aux, m_lba);
    chk("R10", "tx_level", int'(tx_level), m_txl);
    chk("R10", "rx_level", int'(rx_level), m_rxl);
    chk("R7", "cmd_err", cmd_err, m_cerr);
  end

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [AW-1:0] ad, input logic [7:0] dt);
    wr_en = 1; wr_addr = ad; wr_data = dt;
    @(negedge clk);
    wr_en = 0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 5000) begin
    nchk++; nbad++;
    $display("FAIL watchdog actual=%0d expected=<5000", cyc);
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1", "tx_idle_fill", tx_idle_fill, 1);
    chk("R1", "outputs", {tx_active, rx_active, sw_rst, lb_digital, lb_aux, iso_err, cmd_err,
        tx_rst_pulse, tx_en_pulse, tx_level, rx_level}, 0);
    // R2 foreign address and zero write
    wr(8'h01, 8'h33);
    chk("R2", "foreign addr", {tx_active, rx_active, lb_digital, lb_aux}, 0);
    wr(A, 8'h00);
    chk("R2", "zero write", {tx_active, rx_active, cmd_err}, 0);
    // R10 push while disabled
    tx_push = 1; idle(2); tx_push = 0;
    chk("R10", "push while off", int'(tx_level), 0);
    // R3 enables, R10 saturation
    wr(A, 8'h20);
    tx_push = 1; idle(5); tx_push = 0;
    chk("R10", "saturate", int'(tx_level), D);
    wr(A, 8'h10);
    rx_push = 1; idle(2); rx_push = 0;
    // R9 sticky error and clear-wins
    iso_err_set = 1; idle(1); iso_err_set = 0;
    chk("R9", "iso set", iso_err, 1);
    iso_err_set = 1; wr(A, 8'h04); iso_err_set = 0;
    chk("R9", "clear wins", iso_err, 0);
    // R4 tx path reset alone
    wr(A, 8'h80);
    chk("R4", "tx cleared", {tx_active, tx_level}, 0);
    chk("R4", "rx untouched", int'(rx_level), 2);
    idle(1);
    wr(A, 8'h20);
    tx_push = 1; idle(2); tx_push = 0;
    // R5 combined reset with deferred actions, follow-up write ignored
    wr(A, 8'hE6);
    chk("R5", "reset first", {tx_active, lb_digital, tx_rst_pulse}, 1);
    wr(A, 8'h10);
    chk("R5", "deferred applied", {tx_active, lb_digital, tx_en_pulse}, 7);
    idle(1);
    chk("R5", "write in deferred cycle ignored", rx_active, 0);
    // R7 illegal combination
    wr(A, 8'h0C);
    chk("R7", "illegal flagged", {cmd_err, sw_rst, tx_active}, 5);
    wr(A, 8'h00);
    chk("R7", "cleared by legal", cmd_err, 0);
    // R8 auxiliary loopback, then R6 software reset
    wr(A, 8'h01);
    wr(A, 8'h00);
    chk("R8", "loops sticky", {lb_digital, lb_aux}, 3);
    iso_err_set = 1; wr(A, 8'h08); iso_err_set = 0;
    chk("R6", "sw reset entered", {sw_rst, tx_active, lb_digital, lb_aux, iso_err}, 16);
    wr(A, 8'h28);
    tx_push = 1; idle(2); tx_push = 0;
    chk("R6", "held in reset", {sw_rst, tx_active, tx_level}, 1 << (LW + 1));
    wr(A, 8'h20);
    chk("R6", "exit ignores other bits", {sw_rst, tx_active}, 0);
    idle(2);
    wr(A, 8'h30);
    chk("R3", "works after exit", {tx_active, rx_active}, 3);
    idle(3);
    finish_run();
  end
endmodule